// File: doc/BRIEF.md
# Floating-Point Special-Operand and Exception Gate

This block sits beside a single-precision arithmetic core and decides, for each issued operation, what happens to the destination register and which exception is flagged. It sorts every operand into a class: zero, normal, infinity, quiet NaN or signalling NaN. Denormals count as zero, and rounding is taken as nearest-only. From the operand classes it detects invalid operations and division by zero for add, subtract, multiply, divide, reciprocal square root and the four fused multiply-add forms. If the operation is neither invalid nor a division by zero, it folds the overflow, underflow and inexact flags reported by the core into a single recorded exception.

The block holds a five-bit enable field and a five-bit cause field. In both fields, bit 4 is invalid (V), bit 3 is divide-by-zero (Z), bit 2 is overflow (O), bit 1 is underflow (U) and bit 0 is inexact (I). When an exception is enabled, the destination write is suppressed and the cause bit is set. When it is disabled, a default value is written instead. Software or the pipeline loads the enables through a simple load strobe. A trap request stays asserted while any cause bit is set.

One cycle after an operation is issued, the block reports whether the destination is written and which source supplies the value. `res_kind` encodes the source: 0 means the core result, 1 means the canonical quiet NaN, 2 means +0, and 3 means an infinity whose sign is given by `res_sign`.

Top module: `fpx_gate`

## Requirements
- R1: While reset is applied and on the first cycle after it, enables, causes, `res_we` and `trap_req` are all zero.
- R2: When `en_load` is high at a clock edge, `enables` takes `en_value` (V=bit4, Z=3, O=2, U=1, I=0) from the next cycle. An operation issued in the same cycle uses the previous enables.
- R3: Each accepted operation (`op_valid` high) replaces the cause field entirely, and the decision appears one cycle later. Without `op_valid`, `res_we` is 0 and the causes hold. Op codes are: 0 add, 1 sub, 2 mul, 3 div, 4 reciprocal square root (operand a only), 5 a*b+c, 6 a*b-c, 7 -(a*b)+c, 8 -(a*b)-c.
- R4: An operand with exponent field 0 is zero, including denormals. An operand with an all-ones exponent is infinity if its fraction is 0, a quiet NaN if the fraction MSB is 1, and a signalling NaN otherwise. Every other operand is normal.
- R5: Add is invalid for a signalling NaN operand, or for infinities of opposite sign. Sub is invalid for a signalling NaN operand, or for infinities of the same sign.
- R6: Mul is invalid for a signalling NaN operand, or for infinity times zero in either order. Div is invalid for a signalling NaN operand, inf/inf, or 0/0.
- R7: For an invalid operation, if V is enabled the result is cause V with no write. Otherwise the quiet NaN is written (kind 1) and the causes are clear.
- R8: Dividing a normal number by zero with Z enabled gives cause Z and no write. With Z disabled, the operation follows the status fold.
- R9: For reciprocal square root, a signalling NaN, -inf or a negative normal is invalid. A quiet NaN writes the quiet NaN. +inf writes +0 (kind 2). A zero of either sign gives cause Z if Z is enabled; otherwise it writes an infinity of the operand's sign (kind 3). A positive normal follows the fold.
- R10: The fused forms are invalid for a signalling NaN in any operand, or for infinity times zero. They are also invalid when the product is infinite (no NaN factor), the addend is infinite, and the two would cancel.
- R11: The fold checks overflow, then underflow, then inexact. The first flag that is raised and also enabled is recorded as the only cause, and the write is suppressed. If no flag qualifies, the core result is written (kind 0).
- R12: `trap_req` is high exactly while the cause field is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation issued this cycle |
| op_code | input | 4 | Operation select (see R3) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| opnd_c | input | 32 | Addend for the fused forms |
| core_ovf | input | 1 | Core reports overflow |
| core_unf | input | 1 | Core reports underflow or denormal result |
| core_inx | input | 1 | Core reports inexact or rounded result |
| en_load | input | 1 | Load the enable field |
| en_value | input | 5 | New enable field |
| enables | output | 5 | Current enable field |
| cause | output | 5 | Cause field of the last operation |
| res_we | output | 1 | Destination is written |
| res_kind | output | 2 | Written value source |
| res_sign | output | 1 | Sign of a written infinity |
| trap_req | output | 1 | Trap request |

## Verification
Cancelling infinities in the fused forms are the hardest case to reach from the ports. An infinite product needs a non-NaN infinite factor together with a nonzero, non-NaN partner. The addend must also be infinite with the exact sign that cancels for the chosen form. Random operands rarely line this up, so directed cycles walk all four fused forms with both addend signs. Random cycles then draw operands from a small pool weighted towards infinities, zeros and NaNs. The fold priority is hard to reach for a similar reason: a higher flag must be raised while masked and a lower one enabled. The stimulus therefore sets flag and enable patterns that cross in this way.

// File: rtl/fpx_pkg.sv
`timescale 1ns/1ps
package fpx_pkg;
  typedef enum logic [2:0] {
    CL_ZERO = 3'd0,
    CL_NORM = 3'd1,
    CL_INF  = 3'd2,
    CL_QNAN = 3'd3,
    CL_SNAN = 3'd4
  } fcls_e;

  typedef struct packed {
    logic  sgn;
    fcls_e cls;
  } fopnd_t;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_DIV  = 4'd3,
    OP_RSQ  = 4'd4,
    OP_FMA  = 4'd5,
    OP_FMS  = 4'd6,
    OP_FNMA = 4'd7,
    OP_FNMS = 4'd8
  } fop_e;

  typedef enum logic [1:0] {
    RK_CORE = 2'd0,
    RK_QNAN = 2'd1,
    RK_ZERO = 2'd2,
    RK_INF  = 2'd3
  } rkind_e;

  localparam int NEXC = 5;
  localparam int XV = 4;
  localparam int XZ = 3;
  localparam int XO = 2;
  localparam int XU = 1;
  localparam int XI = 0;
endpackage

// File: rtl/fpx_classify.sv
`timescale 1ns/1ps
module fpx_classify
  import fpx_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] word,
  output fopnd_t               info
);
  function automatic fcls_e cls_of(input logic [EXP_W-1:0] e, input logic [MAN_W-1:0] f);
    if (e == '0) return CL_ZERO;
    if (e != '1) return CL_NORM;
    if (f == '0) return CL_INF;
    return f[MAN_W-1] ? CL_QNAN : CL_SNAN;
  endfunction

  assign info.sgn = word[EXP_W+MAN_W];
  assign info.cls = cls_of(word[EXP_W+MAN_W-1:MAN_W], word[MAN_W-1:0]);
endmodule

// File: rtl/fpx_screen.sv
`timescale 1ns/1ps
module fpx_screen
  import fpx_pkg::*;
(
  input  fop_e   op,
  input  fopnd_t oa,
  input  fopnd_t ob,
  input  fopnd_t oc,
  output logic   invalid,
  output logic   div_zero,
  output logic   rsq_zero,
  output logic   rsq_direct,
  output rkind_e rsq_kind
);
  function automatic logic is_nan(input fopnd_t x);
    return (x.cls == CL_QNAN) || (x.cls == CL_SNAN);
  endfunction

  logic any_snan2, any_snan3, inf_x_zero, prod_inf, prod_sgn, cancel;

  always_comb begin
    any_snan2  = (oa.cls == CL_SNAN) || (ob.cls == CL_SNAN);
    any_snan3  = any_snan2 || (oc.cls == CL_SNAN);
    inf_x_zero = ((oa.cls == CL_INF) && (ob.cls == CL_ZERO)) ||
                 ((oa.cls == CL_ZERO) && (ob.cls == CL_INF));
    prod_inf   = ((oa.cls == CL_INF) || (ob.cls == CL_INF)) && !is_nan(oa) && !is_nan(ob);
    prod_sgn   = oa.sgn ^ ob.sgn;
    cancel     = 1'b0;
    if (prod_inf && (oc.cls == CL_INF)) begin
      unique case (op)
        OP_FMA, OP_FNMS: cancel = (prod_sgn != oc.sgn);
        OP_FMS, OP_FNMA: cancel = (prod_sgn == oc.sgn);
        default:         cancel = 1'b0;
      endcase
    end

    invalid    = 1'b0;
    div_zero   = 1'b0;
    rsq_zero   = 1'b0;
    rsq_direct = 1'b0;
    rsq_kind   = RK_CORE;
    unique case (op)
      OP_ADD: invalid = any_snan2 || ((oa.cls == CL_INF) && (ob.cls == CL_INF) && (oa.sgn != ob.sgn));
      OP_SUB: invalid = any_snan2 || ((oa.cls == CL_INF) && (ob.cls == CL_INF) && (oa.sgn == ob.sgn));
      OP_MUL: invalid = any_snan2 || inf_x_zero;
      OP_DIV: begin
        invalid  = any_snan2 || ((oa.cls == CL_INF) && (ob.cls == CL_INF)) ||
                   ((oa.cls == CL_ZERO) && (ob.cls == CL_ZERO));
        div_zero = (oa.cls == CL_NORM) && (ob.cls == CL_ZERO);
      end
      OP_RSQ: begin
        invalid  = (oa.cls == CL_SNAN) || (oa.sgn && ((oa.cls == CL_NORM) || (oa.cls == CL_INF)));
        rsq_zero = (oa.cls == CL_ZERO);
        if (oa.cls == CL_QNAN) begin
          rsq_direct = 1'b1;
          rsq_kind   = RK_QNAN;
        end else if ((oa.cls == CL_INF) && !oa.sgn) begin
          rsq_direct = 1'b1;
          rsq_kind   = RK_ZERO;
        end
      end
      OP_FMA, OP_FMS, OP_FNMA, OP_FNMS: invalid = any_snan3 || inf_x_zero || cancel;
      default: invalid = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpx_fold.sv
`timescale 1ns/1ps
module fpx_fold
  import fpx_pkg::*;
(
  input  logic [NEXC-1:0] en,
  input  logic            ovf,
  input  logic            unf,
  input  logic            inx,
  output logic [NEXC-1:0] fcause,
  output logic            pass
);
  always_comb begin
    fcause = '0;
    pass   = 1'b1;
    if (ovf && en[XO]) begin
      fcause[XO] = 1'b1;
      pass       = 1'b0;
    end else if (unf && en[XU]) begin
      fcause[XU] = 1'b1;
      pass       = 1'b0;
    end else if (inx && en[XI]) begin
      fcause[XI] = 1'b1;
      pass       = 1'b0;
    end
  end
endmodule

// File: rtl/fpx_gate.sv
`timescale 1ns/1ps
module fpx_gate
  import fpx_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid,
  input  logic [3:0]              op_code,
  input  logic [EXP_W+MAN_W:0]    opnd_a,
  input  logic [EXP_W+MAN_W:0]    opnd_b,
  input  logic [EXP_W+MAN_W:0]    opnd_c,
  input  logic                    core_ovf,
  input  logic                    core_unf,
  input  logic                    core_inx,
  input  logic                    en_load,
  input  logic [4:0]              en_value,
  output logic [4:0]              enables,
  output logic [4:0]              cause,
  output logic                    res_we,
  output logic [1:0]              res_kind,
  output logic                    res_sign,
  output logic                    trap_req
);
  localparam int W     = EXP_W + MAN_W + 1;
  localparam int NOPND = 3;

  logic [NOPND-1:0][W-1:0] words;
  fopnd_t                  info [NOPND];
  assign words = {opnd_c, opnd_b, opnd_a};

  for (genvar g = 0; g < NOPND; g++) begin : g_cls
    fpx_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .word(words[g]),
      .info(info[g])
    );
  end

  fop_e op;
  assign op = fop_e'(op_code);

  logic   flag_invalid, flag_divz, flag_rsqz, flag_rsqd;
  rkind_e rsq_kind;
  fpx_screen u_screen (
    .op        (op),
    .oa        (info[0]),
    .ob        (info[1]),
    .oc        (info[2]),
    .invalid   (flag_invalid),
    .div_zero  (flag_divz),
    .rsq_zero  (flag_rsqz),
    .rsq_direct(flag_rsqd),
    .rsq_kind  (rsq_kind)
  );

  logic [NEXC-1:0] fold_cause;
  logic            fold_pass;
  fpx_fold u_fold (
    .en    (enables),
    .ovf   (core_ovf),
    .unf   (core_unf),
    .inx   (core_inx),
    .fcause(fold_cause),
    .pass  (fold_pass)
  );

  logic [NEXC-1:0] nxt_cause;
  logic            nxt_we, nxt_sign;
  rkind_e          nxt_kind;

  always_comb begin
    nxt_cause = '0;
    nxt_we    = 1'b0;
    nxt_kind  = RK_CORE;
    nxt_sign  = 1'b0;
    if (flag_invalid) begin
      if (enables[XV]) nxt_cause[XV] = 1'b1;
      else begin
        nxt_we   = 1'b1;
        nxt_kind = RK_QNAN;
      end
    end else if (flag_divz && enables[XZ]) begin
      nxt_cause[XZ] = 1'b1;
    end else if (flag_rsqz) begin
      if (enables[XZ]) nxt_cause[XZ] = 1'b1;
      else begin
        nxt_we   = 1'b1;
        nxt_kind = RK_INF;
        nxt_sign = info[0].sgn;
      end
    end else if (flag_rsqd) begin
      nxt_we   = 1'b1;
      nxt_kind = rsq_kind;
    end else begin
      nxt_cause = fold_cause;
      nxt_we    = fold_pass;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enables  <= '0;
      cause    <= '0;
      res_we   <= 1'b0;
      res_kind <= RK_CORE;
      res_sign <= 1'b0;
      trap_req <= 1'b0;
    end else begin
      if (en_load) enables <= en_value;
      res_we <= op_valid && nxt_we;
      if (op_valid) begin
        cause    <= nxt_cause;
        res_kind <= nxt_kind;
        res_sign <= nxt_sign;
        trap_req <= |nxt_cause;
      end
    end
  end
endmodule

// File: rtl/fpx_gate_chk.sv
`timescale 1ns/1ps
module fpx_gate_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [3:0]   op_code,
  input logic [W-1:0] opnd_a,
  input logic         en_load,
  input logic [4:0]   en_value,
  input logic [4:0]   enables,
  input logic [4:0]   cause,
  input logic         res_we,
  input logic [1:0]   res_kind,
  input logic         trap_req,
  input logic         flag_invalid
);
  localparam logic [W-1:0] POS_INF = {1'b0, {(W-24){1'b1}}, 23'd0};

  p_trap_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req == (cause != 5'd0));

  p_single_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause));

  p_write_means_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> (cause == 5'd0));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_we && $stable(cause)));

  p_enable_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_load |=> (enables == $past(en_value)));

  p_invalid_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && flag_invalid && !enables[4]) |=> (res_we && res_kind == 2'd1));

  p_rsq_pinf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd4 && opnd_a == POS_INF) |=> (res_we && res_kind == 2'd2));
endmodule

bind fpx_gate fpx_gate_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .op_code     (op_code),
  .opnd_a      (opnd_a),
  .en_load     (en_load),
  .en_value    (en_value),
  .enables     (enables),
  .cause       (cause),
  .res_we      (res_we),
  .res_kind    (res_kind),
  .trap_req    (trap_req),
  .flag_invalid(flag_invalid)
);

// File: tb/test_fpx_gate.sv
`timescale 1ns/1ps
module test_fpx_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
  logic        core_ovf = 1'b0, core_unf = 1'b0, core_inx = 1'b0;
  logic        en_load = 1'b0;
  logic [4:0]  en_value = '0;
  logic [4:0]  enables, cause;
  logic        res_we, res_sign, trap_req;
  logic [1:0]  res_kind;

  always #2.5 clk = ~clk;

  fpx_gate i_fpx_gate (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
    .core_ovf(core_ovf), .core_unf(core_unf), .core_inx(core_inx),
    .en_load(en_load), .en_value(en_value), .enables(enables), .cause(cause),
    .res_we(res_we), .res_kind(res_kind), .res_sign(res_sign), .trap_req(trap_req)
  );

  localparam logic [31:0] PINF = 32'h7f80_0000, NINF = 32'hff80_0000;
  localparam logic [31:0] QN = 32'h7fc0_0000, SN = 32'h7fa0_0000, NSN = 32'hff80_0001;
  localparam logic [31:0] ONE = 32'h3f80_0000, MONE = 32'hbf80_0000;
  localparam logic [31:0] PZ = 32'h0, NZ = 32'h8000_0000;
  localparam logic [31:0] DEN = 32'h0000_0001, NDEN = 32'h8040_0000;

  int errors = 0, checks = 0;
  logic [4:0] m_en = '0, m_cause = '0;
  logic       m_we = 1'b0, m_sign = 1'b0;
  logic [1:0] m_kind = '0;

  function automatic logic t_zero(input logic [31:0] x); return x[30:23] == 8'd0; endfunction
  function automatic logic t_inf(input logic [31:0] x); return x[30:23] == 8'hff && x[22:0] == 0; endfunction
  function automatic logic t_qn(input logic [31:0] x); return x[30:23] == 8'hff && x[22]; endfunction
  function automatic logic t_sn(input logic [31:0] x); return x[30:23] == 8'hff && !x[22] && x[21:0] != 0; endfunction
  function automatic logic t_num(input logic [31:0] x); return !t_zero(x) && x[30:23] != 8'hff; endfunction

  // returns {cause[4:0], we, kind[1:0], sign}
  function automatic logic [8:0] ref_eval(input int op, input logic [31:0] a, b, c,
                                          input logic ov, un, ix, input logic [4:0] en);
    logic bad, pinf, fz, done;
    logic [4:0] cs;
    logic we, sg;
    logic [1:0] kd;
    logic [2:0] flags;
    bad = 0; fz = 0; cs = 0; we = 0; kd = 0; sg = 0; done = 0;
    pinf = (t_inf(a) || t_inf(b)) && !t_qn(a) && !t_sn(a) && !t_qn(b) && !t_sn(b);
    case (op)
      0: bad = t_sn(a) || t_sn(b) || (t_inf(a) && t_inf(b) && a[31] != b[31]);
      1: bad = t_sn(a) || t_sn(b) || (t_inf(a) && t_inf(b) && a[31] == b[31]);
      2: bad = t_sn(a) || t_sn(b) || (t_inf(a) && t_zero(b)) || (t_zero(a) && t_inf(b));
      3: bad = t_sn(a) || t_sn(b) || (t_inf(a) && t_inf(b)) || (t_zero(a) && t_zero(b));
      4: bad = t_sn(a) || (a[31] && (t_num(a) || t_inf(a)));
      default: begin
        bad = t_sn(a) || t_sn(b) || t_sn(c) || (t_inf(a) && t_zero(b)) || (t_zero(a) && t_inf(b));
        if (pinf && t_inf(c)) begin
          if (op == 5 || op == 8) bad = bad || ((a[31] ^ b[31]) != c[31]);
          else                    bad = bad || ((a[31] ^ b[31]) == c[31]);
        end
      end
    endcase
    if (bad) begin
      done = 1;
      if (en[4]) cs = 5'b10000; else begin we = 1; kd = 2'd1; end
    end else if (op == 3 && t_num(a) && t_zero(b) && en[3]) begin
      done = 1; cs = 5'b01000;
    end else if (op == 4) begin
      if (t_zero(a)) begin
        done = 1;
        if (en[3]) cs = 5'b01000; else begin we = 1; kd = 2'd3; sg = a[31]; end
      end else if (t_qn(a)) begin done = 1; we = 1; kd = 2'd1; end
      else if (t_inf(a)) begin done = 1; we = 1; kd = 2'd2; end
    end
    if (!done) begin
      flags = {ov, un, ix};
      we = 1;
      for (int k = 2; k >= 0; k--) begin
        if (we && flags[k] && en[k]) begin cs[k] = 1; we = 0; end
      end
    end
    return {cs, we, kd, sg};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(32'(enables), 32'(m_en), "enables", tag);
    check(32'(cause), 32'(m_cause), "cause", tag);
    check(32'(res_we), 32'(m_we), "res_we", tag);
    check(32'(trap_req), 32'(m_cause != 0), "trap_req R12", tag);
    if (m_we) check(32'(res_kind), 32'(m_kind), "res_kind", tag);
    if (m_we && m_kind == 2'd3) check(32'(res_sign), 32'(m_sign), "res_sign", tag);
  endtask

  task automatic cyc(input logic v, input int op, input logic [31:0] a, b, c,
                     input logic ov, un, ix, input logic ld, input logic [4:0] ev, input string tag);
    logic [8:0] r;
    op_valid = v; op_code = 4'(op); opnd_a = a; opnd_b = b; opnd_c = c;
    core_ovf = ov; core_unf = un; core_inx = ix; en_load = ld; en_value = ev;
    r = ref_eval(op, a, b, c, ov, un, ix, m_en);
    if (v) begin
      m_cause = r[8:4]; m_we = r[3]; m_kind = r[2:1]; m_sign = r[0];
    end else m_we = 0;
    if (ld) m_en = ev;
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic op1(input int op, input logic [31:0] a, b, c, input string tag);
    cyc(1, op, a, b, c, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic set_en(input logic [4:0] ev);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, ev, "R2");
  endtask

  logic [31:0] pool [10];

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    pool = '{PINF, NINF, QN, SN, ONE, MONE, PZ, NZ, DEN, NSN};
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    compare_all("R1 after reset");

    // defaults: all enables off
    op1(0, PINF, NINF, 0, "R5 R7 add inf-inf qnan");
    op1(1, NINF, NINF, 0, "R5 sub same-sign inf");
    op1(1, PINF, NINF, 0, "R5 sub valid");
    op1(2, DEN, PINF, 0, "R4 R6 denormal times inf");
    op1(3, NZ, PZ, 0, "R6 zero over zero");
    op1(3, ONE, PZ, 0, "R8 div zero masked");
    op1(0, QN, ONE, 0, "R4 qnan add not invalid");
    op1(4, NZ, 0, 0, "R9 rsqrt -0 to -inf");
    op1(4, NDEN, 0, 0, "R4 R9 neg denormal as zero");
    op1(4, PINF, 0, 0, "R9 rsqrt +inf");
    op1(4, QN, 0, 0, "R9 rsqrt qnan");
    op1(4, MONE, 0, 0, "R9 rsqrt negative");

    set_en(5'b11111);
    op1(2, NSN, ONE, 0, "R6 R7 snan mul trapped");
    op1(3, MONE, NZ, 0, "R8 div zero trapped");
    op1(4, PZ, 0, 0, "R9 rsqrt zero Z trapped");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 idle holds");
    op1(3, PINF, PINF, 0, "R6 inf over inf");
    op1(0, ONE, ONE, 0, "R3 causes cleared");
    // fused cancellation
    op1(5, PINF, ONE, NINF, "R10 fma cancel");
    op1(5, PINF, ONE, PINF, "R10 fma no cancel");
    op1(6, NINF, MONE, PINF, "R10 fms cancel");
    op1(6, NINF, ONE, PINF, "R10 fms no cancel");
    op1(7, ONE, PINF, PINF, "R10 fnma cancel");
    op1(7, ONE, NINF, PINF, "R10 fnma no cancel");
    op1(8, MONE, PINF, PINF, "R10 fnms cancel");
    op1(8, MONE, PINF, NINF, "R10 fnms no cancel");
    op1(5, QN, PINF, PINF, "R10 nan factor");
    op1(5, ONE, ONE, SN, "R10 snan addend");
    op1(6, PZ, NINF, ONE, "R10 inf times zero");
    // fold priority
    cyc(1, 0, ONE, ONE, 0, 1, 1, 1, 0, 0, "R11 ovf wins");
    set_en(5'b00011);
    cyc(1, 2, ONE, ONE, 0, 1, 1, 1, 0, 0, "R11 masked ovf then unf");
    set_en(5'b00001);
    cyc(1, 1, ONE, ONE, 0, 1, 1, 1, 0, 0, "R11 inexact only");
    cyc(1, 4, ONE, 0, 0, 1, 1, 0, 0, 0, "R11 nothing enabled qualifies");
    cyc(1, 3, ONE, ONE, 0, 0, 0, 1, 1, 5'b00000, "R2 same-cycle load uses old");
    cyc(1, 3, ONE, ONE, 0, 0, 0, 1, 0, 0, "R2 new enables used");
    set_en(5'b10000);
    op1(4, PZ, 0, 0, "R9 rsqrt +0 to +inf");

    for (int i = 0; i < 600; i++) begin
      automatic int op = int'($urandom_range(8));
      automatic logic [2:0] fl = 3'($urandom);
      automatic logic ld = ($urandom_range(7) == 0);
      cyc($urandom_range(5) != 0, op, pool[$urandom_range(9)], pool[$urandom_range(9)],
          pool[$urandom_range(9)], fl[2], fl[1], fl[0], ld, 5'($urandom), "R3 R11 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule